// File: doc/BRIEF.md
# I2C Serial Memory Target (Read Path)

This block is a two-wire serial bus target that sits in front of a byte-wide array of 2^ADDR_W locations (4096 by default). SCL and SDA are sampled with the system clock, and START and STOP are recognised from the synchronised samples. The target answers only to its own 7-bit device address. It drives SDA through an open-drain style pull-down enable and never drives the line high.

Three read styles are served from one internal address pointer:

- **Current-address read:** a read with no address phase returns the byte at the pointer.
- **Random read:** a write header carries two address bytes and is then cut short by a repeated START and a read header. The target returns data from the address just loaded.
- **Sequential read:** if the controller acknowledges a byte, the target keeps sending. The pointer steps once per byte and wraps from the last location to zero.

Write data bytes are not stored. The array content is a fixed computed pattern, so the write path only loads the pointer.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the pull-down enable is off and the pointer is 0, so a current-address read returns the cell at address 0.
- R2: A header whose upper 7 bits equal DEV_ADDR is acknowledged by pulling SDA low during the ninth clock. Any other header is not acknowledged, and SDA stays released until the next START.
- R3: A header with R/W = 1 returns the byte at the pointer, MSB first.
- R4: After a header with R/W = 0, the target acknowledges two address bytes. The pointer becomes {first byte[ADDR_W-9:0], second byte}, and a repeated START with a read header returns data from that address.
- R5: When the controller acknowledges a data byte, the next byte follows. When the controller answers NoACK, SDA stays released until the next START.
- R6: The pointer wraps from 2^ADDR_W-1 to 0 during sequential reads.
- R7: The pointer steps by one when each byte is loaded for sending. The sent byte is the one at the pre-step address, and a later current-address read resumes after the last byte sent.
- R8: The target changes its SDA drive only while SCL is low. Its data bits are stable while SCL is high.
- R9: A START or STOP abandons any transfer in progress. An address phase cut short before its second byte completes leaves the pointer unchanged.
- R10: Data bytes that follow the two address bytes in a write are not acknowledged, and they leave the pointer unchanged.
- R11: The bits of the first address byte above the pointer width have no effect on the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench builds the target with ADDR_W = 12, DEV_ADDR = 7'h50 and two synchroniser stages, so the full 4096-location pointer is in play. Random reads placed near 0xFFF reach the wrap to zero within a few bytes. The first address byte carries random junk in its top four bits, which exercises the pointer truncation. Each bus phase lasts five system clocks, which leaves room between SCL edges for the two-stage sampler and the drive register.

// File: rtl/i2cmt_pkg.sv
package i2cmt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_PARK
  } tgt_state_e;

  // Fixed content of the array: a scrambled function of the address.
  function automatic logic [7:0] cell_value(input int unsigned a);
    return 8'(a * 37 + 11) ^ 8'(a >> 5);
  endfunction

  // Header match: upper seven bits against the device address.
  function automatic logic header_hit(input logic [7:0] hdr, input logic [6:0] dev);
    return hdr[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2cmt_sync.sv
module i2cmt_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_pipe;
  logic [LAST:0] sda_pipe;
  logic          scl_d;
  logic          sda_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe[0] <= scl_in;
          sda_pipe[0] <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[LAST-1:0], scl_in};
          sda_pipe <= {sda_pipe[LAST-1:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[LAST];
      sda_d <= sda_pipe[LAST];
    end
  end

  assign scl_s     = scl_pipe[LAST];
  assign sda_s     = sda_pipe[LAST];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cmt_cells.sv
module i2cmt_cells
  import i2cmt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= cell_value(0);
    else        rdata <= cell_value(32'(addr));
  end
endmodule

// File: rtl/i2cmt_ptr.sv
module i2cmt_ptr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_val,
  input  logic              step_en,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (set_en)  ptr <= set_val;
    else if (step_en) ptr <= ptr + ONE;
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2cmt_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  localparam int HI_W = ADDR_W - 8;

  // Sampled bus and its events.
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  // Sequencer state.
  tgt_state_e  state;
  logic [2:0]  bitcnt;
  logic [7:0]  shreg;
  logic        oe_q;
  logic        rw_q;
  logic [HI_W-1:0] hi_q;
  logic        byte_full;
  logic        ack_seen;

  // Named internal events.
  logic              rx_state;
  logic              rx_done;
  logic              dev_hit;
  logic              load_evt;
  logic              set_evt;
  logic [ADDR_W-1:0] set_val;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        cell_q;

  i2cmt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2cmt_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (set_evt),
    .set_val(set_val),
    .step_en(load_evt),
    .ptr    (ptr)
  );

  i2cmt_cells #(.ADDR_W(ADDR_W)) u_cells (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (ptr),
    .rdata(cell_q)
  );

  always_comb begin
    rx_state = (state == ST_DEV) || (state == ST_AHI) || (state == ST_ALO);
    rx_done  = rx_state && scl_fall && byte_full;
    dev_hit  = header_hit(shreg, DEV_ADDR);
    load_evt = scl_fall && (((state == ST_DEV_ACK) && rw_q) ||
                            ((state == ST_TX_ACK) && ack_seen));
    set_evt  = (state == ST_ALO) && rx_done;
    set_val  = {hi_q, shreg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      hi_q      <= '0;
      byte_full <= 1'b0;
      ack_seen  <= 1'b0;
    end else if (stop_evt) begin
      state     <= ST_IDLE;
      oe_q      <= 1'b0;
      bitcnt    <= '0;
      byte_full <= 1'b0;
    end else if (start_evt) begin
      state     <= ST_DEV;
      oe_q      <= 1'b0;
      bitcnt    <= '0;
      byte_full <= 1'b0;
    end else begin
      // Receive shifter, shared by header and address phases.
      if (rx_state && scl_rise && !byte_full) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) byte_full <= 1'b1;
      end

      unique case (state)
        ST_DEV: begin
          if (rx_done) begin
            byte_full <= 1'b0;
            if (dev_hit) begin
              rw_q  <= shreg[0];
              oe_q  <= 1'b1;
              state <= ST_DEV_ACK;
            end else begin
              state <= ST_PARK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall && !rw_q) begin
            oe_q  <= 1'b0;
            state <= ST_AHI;
          end
        end
        ST_AHI: begin
          if (rx_done) begin
            byte_full <= 1'b0;
            hi_q      <= shreg[HI_W-1:0];
            oe_q      <= 1'b1;
            state     <= ST_AHI_ACK;
          end
        end
        ST_AHI_ACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_ALO;
          end
        end
        ST_ALO: begin
          if (rx_done) begin
            byte_full <= 1'b0;
            oe_q      <= 1'b1;
            state     <= ST_ALO_ACK;
          end
        end
        ST_ALO_ACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_PARK;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              oe_q   <= 1'b0;
              bitcnt <= '0;
              state  <= ST_TX_ACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              oe_q   <= ~shreg[6];
              bitcnt <= bitcnt + 3'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) ack_seen <= ~sda_s;
          if (scl_fall && !ack_seen) state <= ST_PARK;
        end
        default: ;
      endcase

      // Byte load for transmission: MSB goes out at once, pointer steps.
      if (load_evt) begin
        shreg  <= cell_q;
        oe_q   <= ~cell_q[7];
        bitcnt <= '0;
        state  <= ST_TX;
      end
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/i2cmt_checker.sv
module i2cmt_checker
  import i2cmt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input tgt_state_e        state,
  input logic [ADDR_W-1:0] ptr,
  input logic              load_evt,
  input logic              set_evt,
  input logic [ADDR_W-1:0] set_val,
  input logic              start_evt,
  input logic              stop_evt
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  a_r8_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  a_r2_quiet_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_PARK) |-> !sda_oe);

  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_DEV && !sda_oe));

  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_oe));

  a_r7_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> ptr == $past(ptr) + ONE);

  a_r4_ptr_loads: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ptr == $past(set_val));

  a_r10_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !set_evt) |=> $stable(ptr));

  a_r3_load_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> state == ST_TX);
endmodule

bind i2c_mem_target i2cmt_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe),
  .state    (state),
  .ptr      (ptr),
  .load_evt (load_evt),
  .set_evt  (set_evt),
  .set_val  (set_val),
  .start_evt(start_evt),
  .stop_evt (stop_evt)
);

// File: tb/i2c_mem_target_tb.sv
module i2c_mem_target_tb;
  localparam int         AW   = 12;
  localparam logic [6:0] DEV  = 7'h50;
  localparam int         Q    = 5;
  localparam int         SIZE = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic tb_pull = 1'b0;
  logic sda_oe;
  logic sda_line;

  int n_vec = 0;
  int n_bad = 0;
  int exp_ptr = 0;

  assign sda_line = ~(tb_pull | sda_oe);

  always #10 clk = ~clk;

  i2c_mem_target #(.ADDR_W(AW), .DEV_ADDR(DEV), .SYNC_STAGES(2)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_in(scl),
    .sda_in(sda_line),
    .sda_oe(sda_oe)
  );

  function automatic int tb_cell(input int a);
    return ((a * 37 + 11) & 255) ^ ((a >> 5) & 255);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tb_pull = 1'b0; tick(Q);
    scl = 1'b1;     tick(2*Q);
    tb_pull = 1'b1; tick(2*Q);
    scl = 1'b0;     tick(Q);
  endtask

  task automatic bus_stop();
    tb_pull = 1'b1; tick(Q);
    scl = 1'b1;     tick(2*Q);
    tb_pull = 1'b0; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      tb_pull = ~b[i]; tick(Q);
      scl = 1'b1;      tick(2*Q);
      scl = 1'b0;      tick(Q);
    end
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    tb_pull = 1'b0; tick(Q);
    scl = 1'b1;     tick(Q);
    ack = ~sda_line; tick(Q);
    scl = 1'b0;     tick(Q);
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d, output logic steady);
    logic s1, s2;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tb_pull = 1'b0; tick(Q);
      scl = 1'b1;     tick(1);
      s1 = sda_line;  tick(2*Q-2);
      s2 = sda_line;  tick(1);
      scl = 1'b0;     tick(Q);
      d[i] = s1;
      if (s1 != s2) steady = 1'b0;
    end
    tb_pull = give_ack; tick(Q);
    scl = 1'b1;         tick(2*Q);
    scl = 1'b0;         tick(Q);
    tb_pull = 1'b0;
  endtask

  task automatic read_run(input int n, input string tag);
    logic [7:0] d;
    logic steady;
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, d, steady);
      check(tag, int'(d), tb_cell(exp_ptr));
      check("R8 stable bits", int'(steady), 1);
      exp_ptr = (exp_ptr + 1) % SIZE;
    end
  endtask

  task automatic cur_read(input int n, input string tag);
    logic ack;
    bus_start();
    write_byte({DEV, 1'b1}, ack);
    check("R2 read header ack", int'(ack), 1);
    read_run(n, tag);
    bus_stop();
  endtask

  task automatic rnd_read(input int addr, input int n, input string tag);
    logic ack;
    logic [7:0] hi;
    hi = 8'(addr >> 8) | 8'({$urandom_range(15, 0), 4'h0});
    bus_start();
    write_byte({DEV, 1'b0}, ack); check("R2 write header ack", int'(ack), 1);
    write_byte(hi, ack);          check("R4 hi byte ack", int'(ack), 1);
    write_byte(8'(addr), ack);    check("R4 lo byte ack", int'(ack), 1);
    bus_start();
    write_byte({DEV, 1'b1}, ack); check("R4 read header ack", int'(ack), 1);
    exp_ptr = addr % SIZE;
    read_run(n, tag);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    logic ack;
    logic [7:0] d;
    logic steady;
    void'($urandom(32'd1234));
    tick(4);
    check("R1 released in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(4);
    check("R1 released after reset", int'(sda_oe), 0);

    // R1 / R3: pointer starts at 0.
    cur_read(1, "R3 current read from reset");

    // R4 / R11: junk in upper hi bits ignored.
    rnd_read(12'h123, 1, "R11 random read");
    // R5 / R7: sequential continues from the step.
    cur_read(5, "R7 sequential current read");

    // R6: wrap from top of array.
    rnd_read(12'hFFD, 6, "R6 wrap read");

    // R2: wrong device address is ignored.
    bus_start();
    write_byte({DEV ^ 7'h01, 1'b1}, ack);
    check("R2 foreign header no ack", int'(ack), 0);
    read_byte(1'b1, d, steady);
    check("R2 bus left released", int'(d), 8'hFF);
    bus_stop();
    cur_read(1, "R2 pointer untouched by foreign header");

    // R10: write data after the address is refused, pointer kept.
    bus_start();
    write_byte({DEV, 1'b0}, ack);
    write_byte(8'h02, ack);
    write_byte(8'h00, ack);
    write_byte(8'h5A, ack);
    check("R10 data byte not acked", int'(ack), 0);
    bus_stop();
    exp_ptr = 12'h200;
    cur_read(2, "R10 read at loaded address");

    // R9: address phase cut by STOP leaves pointer.
    bus_start();
    write_byte({DEV, 1'b0}, ack);
    write_byte(8'h07, ack);
    send_bits(8'hC0, 4);
    bus_stop();
    cur_read(1, "R9 stop aborts address");

    // R9: cut by repeated START.
    bus_start();
    write_byte({DEV, 1'b0}, ack);
    write_byte(8'h09, ack);
    send_bits(8'h3C, 5);
    bus_start();
    write_byte({DEV, 1'b1}, ack);
    check("R9 header after abort ack", int'(ack), 1);
    read_run(1, "R9 start aborts address");
    bus_stop();

    // R5: after NoACK the target stays quiet.
    bus_start();
    write_byte({DEV, 1'b1}, ack);
    read_run(2, "R5 read before noack");
    read_byte(1'b0, d, steady);
    check("R5 released after noack", int'(d), 8'hFF);
    bus_stop();
    cur_read(1, "R5 pointer after noack");

    // Random mix of random and sequential reads.
    for (int it = 0; it < 16; it++) begin
      int a, n;
      a = ($urandom_range(3, 0) == 0) ? SIZE - 1 - $urandom_range(3, 0)
                                      : $urandom_range(SIZE - 1, 0);
      n = $urandom_range(4, 1);
      rnd_read(a, n, "R4 random read mix");
      cur_read($urandom_range(3, 1), "R7 follow-on read");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule